// File: doc/BRIEF.md
# Timer Interrupt Router With Legacy Override

This block sits between a bank of event timers and the chip's interrupt fabric. Each timer presents a pending status, a one-cycle event strobe, and its configuration bits: interrupt enable, level or edge mode, message delivery enable, a 5-bit line select and a 64-bit message word. The router turns these requests into levels or single-cycle pulses on 32 interrupt lines. Several timers that select the same line are ORed onto it.

A legacy override mode takes two fixed lines away from the timers' line selects. In this mode timer 0 owns line 0 and timer 1 owns line 8. When the mode is off, two external legacy sources reach those same two lines directly: a periodic-tick source on line 0 and a real-time-clock source on line 8. A gate output tells the periodic-tick source whether it may run.

A timer set for message delivery drives no line. Each of its events instead posts one 32-bit memory write on a valid/ready port.

Top module: `timer_irq_router`

## Requirements
- R1: After reset, every interrupt line is low, `pit_en_o` is high and `msg_valid` is low.
- R2: A level-mode timer (`tmr_level`=1) with its interrupt enable set drives the line given by its 5-bit select `tmr_route[i*5 +: 5]` high while its pending bit is high. The line falls once the pending bit clears. Lines are registered and follow their inputs one clock later.
- R3: An edge-mode timer (`tmr_level`=0) produces a pulse of exactly one clock on its selected line for each cycle in which its `tmr_evt` strobe is high.
- R4: A timer reaches no line and posts no message unless both its own interrupt enable and `glb_en` are high.
- R5: With `legacy_en` high, timer 0 drives line 0 and timer 1 drives line 8, whatever their line selects hold. Timers 2 and above keep using their own selects.
- R6: With `legacy_en` low, `pit_in` is ORed onto line 0 and `rtc_in` is ORed onto line 8.
- R7: While `legacy_en` is high, `pit_in` and `rtc_in` have no effect on any line, and `pit_en_o` is low one clock after the mode turns on.
- R8: One clock after `legacy_en` falls, `pit_en_o` is high and line 8 shows the present `rtc_in` level, including any change made while the mode was on.
- R9: A timer with `tmr_msg_en` set drives no line. For each event it posts one write whose data is bits 31:0 and whose address is bits 63:32 of its word `tmr_msg_word[i*64 +: 64]`. The word is captured in the cycle of the event.
- R10: A posted write is offered on `msg_valid`/`msg_addr`/`msg_data` two clocks after its event. It is held unchanged until `msg_ready` is high at a clock edge. Each timer holds one posted write. When several are waiting, the lowest timer index is offered first.
- R11: When `glb_en` rises, every timer whose interrupt enable and pending bit are both set is handled as if it had an event in that cycle. An edge-mode timer pulses its line, and a message-mode timer posts a write.
- R12: Requests from several timers that select the same line are ORed onto it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy override mode |
| tmr_evt | input | NUM_TIMERS | Per-timer one-cycle event strobe |
| tmr_pend | input | NUM_TIMERS | Per-timer pending status |
| tmr_int_en | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_level | input | NUM_TIMERS | 1 = level mode, 0 = edge mode |
| tmr_msg_en | input | NUM_TIMERS | Per-timer message delivery enable |
| tmr_route | input | NUM_TIMERS*5 | Per-timer line select |
| tmr_msg_word | input | NUM_TIMERS*64 | Per-timer message word: address high, data low |
| pit_in | input | 1 | External periodic-tick interrupt source |
| rtc_in | input | 1 | External real-time-clock interrupt source |
| irq_o | output | 32 | Interrupt lines |
| pit_en_o | output | 1 | Run gate for the periodic-tick source |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Every line result and `pit_en_o` is due one clock after the stimulus that causes it. The bench changes inputs on a falling edge and checks the lines on the next falling edge. An edge-mode pulse is checked on that falling edge, and its fall is checked one falling edge later. A posted write appears two clocks after its event. The driver pushes the expected address and data into a queue, and a monitor pops and compares an entry on each rising edge where `msg_valid` and `msg_ready` are both high, so the result is checked in its own handshake cycle and not at a fixed delay.

// File: rtl/tir_pkg.sv
package tir_pkg;
  // Lines claimed by the legacy override mode; the two owners are timers 0 and 1.
  localparam int PIT_LINE = 0;
  localparam int RTC_LINE = 8;
  localparam int ROUTE_W  = 5;
  localparam int WORD_W   = 64;
endpackage

// File: rtl/tir_route_map.sv
module tir_route_map
  import tir_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_LINES  = 32,
  parameter int RW         = ROUTE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     glb_en,
  input  logic                     legacy_en,
  input  logic [NUM_TIMERS-1:0]    tmr_evt,
  input  logic [NUM_TIMERS-1:0]    tmr_pend,
  input  logic [NUM_TIMERS-1:0]    tmr_int_en,
  input  logic [NUM_TIMERS-1:0]    tmr_level,
  input  logic [NUM_TIMERS-1:0]    tmr_msg_en,
  input  logic [NUM_TIMERS*RW-1:0] tmr_route,
  output logic [NUM_LINES-1:0]     line_drv,
  output logic [NUM_TIMERS-1:0]    msg_post
);
  logic                  glb_q;
  logic                  glb_rise;
  logic [NUM_TIMERS-1:0] evt_eff;
  logic [NUM_TIMERS-1:0] gate;
  logic [NUM_TIMERS-1:0] wire_req;
  logic [RW-1:0]         dest [NUM_TIMERS];

  always_ff @(posedge clk) begin
    if (rst) glb_q <= 1'b0;
    else     glb_q <= glb_en;
  end

  // Global enable rising replays every enabled, pending timer as an event.
  assign glb_rise = glb_en & ~glb_q;
  assign evt_eff  = tmr_evt | ({NUM_TIMERS{glb_rise}} & tmr_pend);
  assign gate     = tmr_int_en & {NUM_TIMERS{glb_en}};
  assign wire_req = gate & ~tmr_msg_en &
                    ((tmr_level & tmr_pend) | (~tmr_level & evt_eff));
  assign msg_post = gate & tmr_msg_en & evt_eff;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dest
    if (i == 0) begin : g_t0
      assign dest[i] = legacy_en ? RW'(PIT_LINE) : tmr_route[i*RW +: RW];
    end else if (i == 1) begin : g_t1
      assign dest[i] = legacy_en ? RW'(RTC_LINE) : tmr_route[i*RW +: RW];
    end else begin : g_tn
      assign dest[i] = tmr_route[i*RW +: RW];
    end
  end

  always_comb begin
    line_drv = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (wire_req[i] && dest[i] == RW'(l)) line_drv[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tir_line_merge.sv
module tir_line_merge
  import tir_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 legacy_en,
  input  logic                 pit_in,
  input  logic                 rtc_in,
  input  logic [NUM_LINES-1:0] line_drv,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 pit_en_o
);
  logic [NUM_LINES-1:0] irq_nxt;

  always_comb begin
    irq_nxt = line_drv;
    if (!legacy_en) begin
      irq_nxt[PIT_LINE] = line_drv[PIT_LINE] | pit_in;
      irq_nxt[RTC_LINE] = line_drv[RTC_LINE] | rtc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= '0;
      pit_en_o <= 1'b1;
    end else begin
      irq_o    <= irq_nxt;
      pit_en_o <= ~legacy_en;
    end
  end

  assert_pass_R6: assert property (@(posedge clk) disable iff (rst)
    !legacy_en |=> (irq_o[PIT_LINE] == $past(pit_in | line_drv[PIT_LINE])) &&
                   (irq_o[RTC_LINE] == $past(rtc_in | line_drv[RTC_LINE])));

  assert_hide_R7: assert property (@(posedge clk) disable iff (rst)
    legacy_en |=> (irq_o[PIT_LINE] == $past(line_drv[PIT_LINE])) &&
                  (irq_o[RTC_LINE] == $past(line_drv[RTC_LINE])));

  assert_pit_gate_R7: assert property (@(posedge clk) disable iff (rst)
    legacy_en |=> !pit_en_o);

  assert_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(legacy_en) |=> pit_en_o && (irq_o[RTC_LINE] == $past(rtc_in | line_drv[RTC_LINE])));
endmodule

// File: rtl/tir_msg_queue.sv
module tir_msg_queue
  import tir_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int AW         = 32,
  parameter int DW         = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_TIMERS-1:0]         msg_post,
  input  logic [NUM_TIMERS*(AW+DW)-1:0] tmr_msg_word,
  input  logic                          msg_ready,
  output logic                          msg_valid,
  output logic [AW-1:0]                 msg_addr,
  output logic [DW-1:0]                 msg_data
);
  localparam int WW = AW + DW;
  localparam int IW = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  logic [NUM_TIMERS-1:0] slot_pend;
  logic [WW-1:0]         slot_word [NUM_TIMERS];
  logic [IW-1:0]         pick;
  logic                  load;

  // Lowest waiting timer index wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_TIMERS - 1; i >= 0; i--) begin
      if (slot_pend[i]) pick = IW'(i);
    end
  end

  assign load = (|slot_pend) && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (msg_post[i]) slot_word[i] <= tmr_msg_word[i*WW +: WW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_pend <= '0;
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (msg_post[i])                    slot_pend[i] <= 1'b1;
        else if (load && pick == IW'(i))    slot_pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= slot_word[pick][WW-1:DW];
      msg_data  <= slot_word[pick][DW-1:0];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import tir_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int NUM_LINES  = 32,
  parameter int AW         = 32,
  parameter int DW         = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            glb_en,
  input  logic                            legacy_en,
  input  logic [NUM_TIMERS-1:0]           tmr_evt,
  input  logic [NUM_TIMERS-1:0]           tmr_pend,
  input  logic [NUM_TIMERS-1:0]           tmr_int_en,
  input  logic [NUM_TIMERS-1:0]           tmr_level,
  input  logic [NUM_TIMERS-1:0]           tmr_msg_en,
  input  logic [NUM_TIMERS*ROUTE_W-1:0]   tmr_route,
  input  logic [NUM_TIMERS*(AW+DW)-1:0]   tmr_msg_word,
  input  logic                            pit_in,
  input  logic                            rtc_in,
  output logic [NUM_LINES-1:0]            irq_o,
  output logic                            pit_en_o,
  output logic                            msg_valid,
  input  logic                            msg_ready,
  output logic [AW-1:0]                   msg_addr,
  output logic [DW-1:0]                   msg_data
);
  logic [NUM_LINES-1:0]  line_drv;
  logic [NUM_TIMERS-1:0] msg_post;

  tir_route_map #(
    .NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES), .RW(ROUTE_W)
  ) u_map (
    .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_en(legacy_en),
    .tmr_evt(tmr_evt), .tmr_pend(tmr_pend), .tmr_int_en(tmr_int_en),
    .tmr_level(tmr_level), .tmr_msg_en(tmr_msg_en), .tmr_route(tmr_route),
    .line_drv(line_drv), .msg_post(msg_post)
  );

  tir_line_merge #(.NUM_LINES(NUM_LINES)) u_merge (
    .clk(clk), .rst(rst), .legacy_en(legacy_en), .pit_in(pit_in),
    .rtc_in(rtc_in), .line_drv(line_drv), .irq_o(irq_o), .pit_en_o(pit_en_o)
  );

  tir_msg_queue #(.NUM_TIMERS(NUM_TIMERS), .AW(AW), .DW(DW)) u_msg (
    .clk(clk), .rst(rst), .msg_post(msg_post), .tmr_msg_word(tmr_msg_word),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );
endmodule

// File: tb/timer_irq_router_tb.sv
module timer_irq_router_tb;
  localparam int NT = 4;
  localparam int NL = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0, legacy_en = 1'b0, pit_in = 1'b0, rtc_in = 1'b0;
  logic [NT-1:0] tmr_evt = '0, tmr_pend = '0, tmr_int_en = '0, tmr_level = '0, tmr_msg_en = '0;
  logic [4:0]  route [NT];
  logic [63:0] word  [NT];
  logic [NT*5-1:0]  tmr_route;
  logic [NT*64-1:0] tmr_msg_word;
  logic [NL-1:0] irq_o;
  logic pit_en_o, msg_valid;
  logic msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q [$];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      tmr_route[i*5 +: 5]     = route[i];
      tmr_msg_word[i*64 +: 64] = word[i];
    end
  end

  timer_irq_router #(.NUM_TIMERS(NT), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_en(legacy_en),
    .tmr_evt(tmr_evt), .tmr_pend(tmr_pend), .tmr_int_en(tmr_int_en),
    .tmr_level(tmr_level), .tmr_msg_en(tmr_msg_en), .tmr_route(tmr_route),
    .tmr_msg_word(tmr_msg_word), .pit_in(pit_in), .rtc_in(rtc_in),
    .irq_o(irq_o), .pit_en_o(pit_en_o), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Monitor: one expected message popped per accepted handshake (R9, R10).
  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected message actual %h expected none", {msg_addr, msg_data});
      end else begin
        chk("R9 message addr/data", {msg_addr, msg_data}, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin route[i] = '0; word[i] = '0; end
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 lines after reset", 64'(irq_o), 64'h0);
    chk("R1 pit_en after reset", 64'(pit_en_o), 64'h1);
    chk("R1 msg_valid after reset", 64'(msg_valid), 64'h0);

    glb_en = 1'b1;
    step();
    // R2 level mode
    route[2] = 5'd5; tmr_level[2] = 1'b1; tmr_int_en[2] = 1'b1; tmr_pend[2] = 1'b1;
    step(); chk("R2 level asserted", 64'(irq_o), 64'(32'h1 << 5));
    tmr_pend[2] = 1'b0;
    step(); chk("R2 level released", 64'(irq_o), 64'h0);

    // R3 edge mode pulse
    route[3] = 5'd12; tmr_int_en[3] = 1'b1; tmr_level[3] = 1'b0; tmr_evt[3] = 1'b1;
    step(); tmr_evt[3] = 1'b0; chk("R3 pulse high", 64'(irq_o), 64'(32'h1 << 12));
    step(); chk("R3 pulse one cycle", 64'(irq_o), 64'h0);

    // R4 gating
    tmr_pend[2] = 1'b1; tmr_int_en[2] = 1'b0;
    step(); chk("R4 timer enable low", 64'(irq_o), 64'h0);
    tmr_int_en[2] = 1'b1; glb_en = 1'b0;
    step(); chk("R4 global enable low", 64'(irq_o), 64'h0);
    glb_en = 1'b1;
    step(); chk("R2 level after global enable", 64'(irq_o), 64'(32'h1 << 5));

    // R12 shared line
    route[3] = 5'd5; tmr_level[3] = 1'b1; tmr_pend[3] = 1'b1;
    step(); tmr_pend[2] = 1'b0;
    step(); chk("R12 shared line held by other timer", 64'(irq_o), 64'(32'h1 << 5));
    tmr_pend[3] = 1'b0;
    step(); chk("R12 shared line released", 64'(irq_o), 64'h0);

    // R6 passthrough
    pit_in = 1'b1;
    step(); chk("R6 pit on line 0", 64'(irq_o), 64'h1);
    rtc_in = 1'b1;
    step(); chk("R6 rtc on line 8", 64'(irq_o), 64'h101);

    // R7 legacy on
    legacy_en = 1'b1;
    step(); chk("R7 inputs hidden", 64'(irq_o), 64'h0);
    chk("R7 pit_en low", 64'(pit_en_o), 64'h0);

    // R5 legacy routing
    route[0] = 5'd20; tmr_level[0] = 1'b1; tmr_int_en[0] = 1'b1; tmr_pend[0] = 1'b1;
    route[1] = 5'd21; tmr_level[1] = 1'b1; tmr_int_en[1] = 1'b1; tmr_pend[1] = 1'b1;
    route[2] = 5'd5;  tmr_level[2] = 1'b1; tmr_pend[2] = 1'b1;
    step(); chk("R5 legacy fixed lines", 64'(irq_o), 64'(32'h1 | (32'h1 << 8) | (32'h1 << 5)));
    tmr_pend = '0;
    step(); chk("R5 legacy released", 64'(irq_o), 64'h0);

    // R8 exit with rtc changed during legacy
    pit_in = 1'b0; rtc_in = 1'b0;
    step(); rtc_in = 1'b1;
    step(); chk("R7 rtc change hidden", 64'(irq_o), 64'h0);
    legacy_en = 1'b0;
    step(); chk("R8 line 8 restored", 64'(irq_o), 64'(32'h1 << 8));
    chk("R8 pit_en high", 64'(pit_en_o), 64'h1);
    rtc_in = 1'b0;
    step();

    // R9 message delivery
    tmr_level = '0;
    tmr_msg_en[3] = 1'b1; word[3] = {32'hFEE0_1000, 32'h0000_0041};
    exp_q.push_back(word[3]);
    msg_ready = 1'b1; tmr_evt[3] = 1'b1;
    step(); tmr_evt[3] = 1'b0; chk("R9 no line for message timer", 64'(irq_o), 64'h0);
    repeat (3) step();
    chk("R9 message delivered", 64'(exp_q.size()), 64'h0);

    // R10 hold and priority
    msg_ready = 1'b0;
    tmr_msg_en[2] = 1'b1; word[2] = {32'hFEE0_2000, 32'h0000_0022};
    word[3] = {32'hFEE0_3000, 32'h0000_0033};
    exp_q.push_back(word[2]); exp_q.push_back(word[3]);
    tmr_evt[2] = 1'b1; tmr_evt[3] = 1'b1;
    step(); tmr_evt = '0; word[2] = 64'hDEAD_BEEF_0BAD_F00D;
    step(); chk("R10 valid two cycles after event", 64'(msg_valid), 64'h1);
    chk("R10 lowest index first", 64'(msg_data), 64'h22);
    repeat (3) step();
    chk("R10 held while stalled", {msg_addr, msg_data}, {32'hFEE0_2000, 32'h0000_0022});
    msg_ready = 1'b1;
    repeat (4) step();
    chk("R10 both messages delivered", 64'(exp_q.size()), 64'h0);
    chk("R10 valid drops when empty", 64'(msg_valid), 64'h0);
    msg_ready = 1'b0; tmr_msg_en = '0;

    // R11 global enable rising replays pending edge timers
    glb_en = 1'b0; route[2] = 5'd9; tmr_pend[2] = 1'b1; tmr_int_en = 4'b0100;
    step(); chk("R11 quiet while disabled", 64'(irq_o), 64'h0);
    glb_en = 1'b1;
    step(); chk("R11 replay pulse", 64'(irq_o), 64'(32'h1 << 9));
    step(); chk("R11 replay one cycle", 64'(irq_o), 64'h0);
    tmr_pend = '0;
    step();

    summary();
    $finish;
  end
endmodule